// File: doc/BRIEF.md
# Buffered-Period PWM Timer Channel

This block is one timer channel that turns a free-running up-counter into a pulse-width-modulated output. Software programs a period value and a duty value through a small write-only register port. It also writes a control word that selects the mode, the output polarity and an optional clock prescaler. In idle mode the counter is stopped, and software may preload it. In run mode the counter walks from 1 up to the period value and then starts again at 1. The output turns active when the counter reaches the duty value and returns to inactive at the end of the period.

Period and duty writes go to shadow copies. While the channel runs, the compare logic only takes up the shadow copies at a period end, so a waveform never shows a mixed cycle. In idle mode the shadow copies reach the compare logic at once. A sticky flag marks every period end. If the channel starts running with a counter value outside 1..period, the period match is missed. The counter then climbs to its all-ones maximum and wraps to 1, and normal operation resumes from there.

Register port: select 0 is control (bit 0 run, bit 1 polarity, bit 2 prescaler enable, bits 7:4 prescale value), select 1 is duty, select 2 is period, select 3 is counter preload, and select 4 is flag clear (bit 0). All control bits at 0 is idle mode.

Top module: `pwm_period_chan`

## Requirements
- R1: A control write with bit 0 clear puts the channel in idle mode and clears the counter to 0 on that clock edge. In idle mode the counter does not move, and the output sits at its inactive level (the pin is the inverse of the polarity bit).
- R2: A write to select 3 loads the counter while the channel is idle. While the channel runs, such a write has no effect on the counter.
- R3: In run mode the counter advances by one per counting tick. When it equals the active period value, the next tick returns it to 1.
- R4: With duty A in 1..B, the output is active while the counter value is at least A and inactive below A. A duty of 1 keeps the output active for the whole period, and a duty of 0 keeps it inactive. Polarity 1 means the active level is high, and polarity 0 means it is low.
- R5: The flag is set by every period-end tick and stays set until a write to select 4 with bit 0 set clears it. A write there with bit 0 clear leaves it alone.
- R6: If the counter is above the period value when run mode is entered, no period end is seen. The counter counts to its all-ones maximum and wraps to 1 without setting the flag, and then periods of the programmed length follow.
- R7: With the prescaler enabled and prescale value p, the counter advances once every p+1 clocks. With the prescaler disabled, it advances on every clock.
- R8: Period and duty writes made while running take effect only after the current period ends. Writes made in idle mode take effect immediately.
- R9: After reset the counter is 0, the flag is clear, the channel is idle and the output pin is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select |
| wr_data | input | CNT_W | Write data |
| pwm_o | output | 1 | PWM output pin |
| cnt_o | output | CNT_W | Current counter value |
| flag_o | output | 1 | Sticky period-end flag |

## Verification
The main function is swept over every duty from 0 to B for each period from 1 to 6, in both polarities. This separates an off-by-one in the duty compare, a missed full or zero duty, and a wrong period restart value. Counter preloads above the period separate a correct climb-and-wrap to 1 from a wrap to 0 or an early flag. Prescale values 0 to 3, plus a disabled prescaler with a nonzero value, separate the divide ratios. Mid-period period rewrites tell shadowed updates from immediate ones.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

    parameter int unsigned PRESC_W        = 4;
    localparam int unsigned CTRL_PRESC_LSB = 4;

    typedef enum logic [2:0] {
        REG_CTRL   = 3'd0,
        REG_DUTY   = 3'd1,
        REG_PERIOD = 3'd2,
        REG_COUNT  = 3'd3,
        REG_FLAG   = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic [PRESC_W-1:0] presc;
        logic               presc_en;
        logic               pol;
        logic               run;
    } ctrl_t;

endpackage

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
    import pwm_chan_pkg::*;
#(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [2:0]       wr_sel_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic             period_end_i,
    output ctrl_t            ctrl_o,
    output logic [CNT_W-1:0] a_act_o,
    output logic [CNT_W-1:0] a_sh_o,
    output logic [CNT_W-1:0] b_act_o,
    output logic             ctrl_wr_o,
    output logic             idle_clr_o,
    output logic             cnt_ld_o,
    output logic             flag_clr_o
);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] a_sh;
        logic [CNT_W-1:0] b_sh;
        logic [CNT_W-1:0] a_act;
        logic [CNT_W-1:0] b_act;
    } regs_t;

    regs_t regs_d, regs_q;
    reg_sel_e sel;

    assign sel = reg_sel_e'(wr_sel_i);

    always_comb begin
        regs_d     = regs_q;
        ctrl_wr_o  = 1'b0;
        cnt_ld_o   = 1'b0;
        flag_clr_o = 1'b0;
        if (wr_en_i) begin
            case (sel)
                REG_CTRL: begin
                    ctrl_wr_o             = 1'b1;
                    regs_d.ctrl.run       = wr_data_i[0];
                    regs_d.ctrl.pol       = wr_data_i[1];
                    regs_d.ctrl.presc_en  = wr_data_i[2];
                    regs_d.ctrl.presc     = wr_data_i[CTRL_PRESC_LSB +: PRESC_W];
                end
                REG_DUTY:   regs_d.a_sh = wr_data_i;
                REG_PERIOD: regs_d.b_sh = wr_data_i;
                REG_COUNT:  cnt_ld_o    = 1'b1;
                REG_FLAG:   flag_clr_o  = wr_data_i[0];
                default: ;
            endcase
        end
        // Compare values: immediate in idle, buffered to the period end in run mode
        if (!regs_q.ctrl.run) begin
            regs_d.a_act = regs_d.a_sh;
            regs_d.b_act = regs_d.b_sh;
        end else if (period_end_i) begin
            regs_d.a_act = regs_q.a_sh;
            regs_d.b_act = regs_q.b_sh;
        end
        idle_clr_o = ctrl_wr_o && !wr_data_i[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign ctrl_o  = regs_q.ctrl;
    assign a_act_o = regs_q.a_act;
    assign a_sh_o  = regs_q.a_sh;
    assign b_act_o = regs_q.b_act;

    // R8: while running, the compare values only move at a period end
    assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.ctrl.run && !period_end_i) |=> ($stable(b_act_o) && $stable(a_act_o)));

endmodule

// File: rtl/pwm_chan_presc.sv
module pwm_chan_presc
    import pwm_chan_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic               en_i,
    input  logic [PRESC_W-1:0] presc_i,
    input  logic               ctrl_wr_i,
    output logic               tick_o
);

    typedef struct packed {
        logic [PRESC_W-1:0] div;
    } presc_t;

    presc_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        tick_o = run_i && (!en_i || (st_q.div == presc_i));
        if (!run_i || !en_i || tick_o) begin
            st_d.div = '0;
        end else begin
            st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7: a nonzero prescale value never yields two ticks in a row
    assert_presc_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && en_i && (presc_i != '0) && !ctrl_wr_i) |=> !tick_o);

endmodule

// File: rtl/pwm_chan_counter.sv
module pwm_chan_counter #(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             idle_clr_i,
    input  logic             cnt_ld_i,
    input  logic [CNT_W-1:0] ld_val_i,
    input  logic [CNT_W-1:0] a_act_i,
    input  logic [CNT_W-1:0] a_sh_i,
    input  logic [CNT_W-1:0] b_act_i,
    input  logic             flag_clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             active_o,
    output logic             flag_o,
    output logic             period_end_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             active;
        logic             flag;
    } cnt_t;

    cnt_t st_d, st_q;
    logic [CNT_W-1:0] a_cmp;

    always_comb begin
        st_d         = st_q;
        a_cmp        = a_act_i;
        period_end_o = run_i && tick_i && (st_q.cnt == b_act_i);
        if (idle_clr_i) begin
            st_d.cnt    = '0;
            st_d.active = 1'b0;
        end else if (!run_i) begin
            if (cnt_ld_i) begin
                st_d.cnt = ld_val_i;
            end
            st_d.active = 1'b0;
        end else if (tick_i) begin
            if (period_end_o) begin
                st_d.cnt    = CNT_ONE;
                st_d.active = 1'b0;
                a_cmp       = a_sh_i;
            end else if (st_q.cnt == CNT_MAX) begin
                st_d.cnt = CNT_ONE;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            if (st_d.cnt == a_cmp) begin
                st_d.active = 1'b1;
            end
        end
        if (period_end_o) begin
            st_d.flag = 1'b1;
        end else if (flag_clr_i) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o    = st_q.cnt;
    assign active_o = st_q.active;
    assign flag_o   = st_q.flag;

    // R1: idle counter does not move without a load or a clear
    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !cnt_ld_i && !idle_clr_i) |=> $stable(cnt_o));

    // R1: idle output is inactive
    assert_idle_inactive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !active_o);

    // R3: period match restarts at one
    assert_period_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i && !idle_clr_i && (cnt_o == b_act_i)) |=> (cnt_o == CNT_ONE));

    // R5: every period end leaves the flag set
    assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        period_end_o |=> flag_o);

    // R6: wrap at the maximum goes to one
    assert_wrap_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i && !idle_clr_i && (cnt_o == CNT_MAX) && (cnt_o != b_act_i))
        |=> (cnt_o == CNT_ONE));

endmodule

// File: rtl/pwm_period_chan.sv
module pwm_period_chan
    import pwm_chan_pkg::*;
#(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic             pwm_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             flag_o
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] a_act, a_sh, b_act;
    logic             ctrl_wr, idle_clr, cnt_ld, flag_clr;
    logic             tick, period_end, active;

    pwm_chan_regs #(.CNT_W(CNT_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (wr_en),
        .wr_sel_i     (wr_sel),
        .wr_data_i    (wr_data),
        .period_end_i (period_end),
        .ctrl_o       (ctrl),
        .a_act_o      (a_act),
        .a_sh_o       (a_sh),
        .b_act_o      (b_act),
        .ctrl_wr_o    (ctrl_wr),
        .idle_clr_o   (idle_clr),
        .cnt_ld_o     (cnt_ld),
        .flag_clr_o   (flag_clr)
    );

    pwm_chan_presc u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (ctrl.run),
        .en_i      (ctrl.presc_en),
        .presc_i   (ctrl.presc),
        .ctrl_wr_i (ctrl_wr),
        .tick_o    (tick)
    );

    pwm_chan_counter #(.CNT_W(CNT_W)) u_counter (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (ctrl.run),
        .tick_i       (tick),
        .idle_clr_i   (idle_clr),
        .cnt_ld_i     (cnt_ld),
        .ld_val_i     (wr_data),
        .a_act_i      (a_act),
        .a_sh_i       (a_sh),
        .b_act_i      (b_act),
        .flag_clr_i   (flag_clr),
        .cnt_o        (cnt_o),
        .active_o     (active),
        .flag_o       (flag_o),
        .period_end_o (period_end)
    );

    assign pwm_o = active ? ctrl.pol : !ctrl.pol;

endmodule

// File: tb/tb_pwm_period_chan.sv
`timescale 1ns/1ps
module tb_pwm_period_chan;

    localparam int CW   = 8;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_sel = '0;
    logic [CW-1:0] wr_data = '0;
    logic          pwm_o;
    logic [CW-1:0] cnt_o;
    logic          flag_o;

    int checks = 0;
    int errors = 0;

    pwm_period_chan #(.CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .pwm_o(pwm_o), .cnt_o(cnt_o), .flag_o(flag_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int sel, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel[2:0]; wr_data = d[CW-1:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic setup(input int a, input int b, input int c);
        wr(0, 0); wr(1, a); wr(2, b); wr(3, c); wr(4, 1);
    endtask

    task automatic wait_cnt(input int v);
        for (int g = 0; g < 2000 && int'(cnt_o) != v; g++) @(negedge clk);
    endtask

    // R3 R4 R5: one steady period for duty a, period b, polarity pol
    task automatic duty_case(input int a, input int b, input int pol);
        int ep;
        setup(a, b, 1);
        wr(0, 1 | (pol << 1));
        wait_cnt(b);
        @(negedge clk);
        for (int i = 1; i <= b; i++) begin
            chk(int'(cnt_o) == i, "R3", int'(cnt_o), i);
            ep = (a != 0 && i >= a) ? pol : 1 - pol;
            chk(int'(pwm_o) == ep, "R4", int'(pwm_o), ep);
            @(negedge clk);
        end
        chk(int'(cnt_o) == 1, "R3", int'(cnt_o), 1);
        chk(flag_o == 1'b1, "R5", int'(flag_o), 1);
    endtask

    // R7: clocks between counter steps
    task automatic presc_case(input int en, input int p);
        int prev, n, ex;
        setup(3, 8, 1);
        wr(0, 1 | (en << 2) | (p << 4));
        prev = int'(cnt_o);
        for (int g = 0; g < 100 && int'(cnt_o) == prev; g++) @(negedge clk);
        prev = int'(cnt_o);
        n = 0;
        for (int g = 0; g < 100 && int'(cnt_o) == prev; g++) begin
            @(negedge clk);
            n++;
        end
        ex = (en != 0) ? p + 1 : 1;
        chk(n == ex, "R7", n, ex);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int c0, ex, mx;
        bit seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(cnt_o == '0, "R9", int'(cnt_o), 0);
        chk(flag_o == 1'b0, "R9", int'(flag_o), 0);
        chk(pwm_o == 1'b1, "R9", int'(pwm_o), 1);

        // R3 R4 R5 sweep
        for (int pol = 0; pol < 2; pol++)
            for (int b = 1; b <= 6; b++)
                for (int a = 0; a <= b; a++)
                    duty_case(a, b, pol);

        // R7 prescaler
        for (int p = 0; p < 4; p++) presc_case(1, p);
        presc_case(0, 3);

        // R2: idle load, then ignored while running
        setup(2, 6, 1);
        wr(3, 5);
        chk(int'(cnt_o) == 5, "R2", int'(cnt_o), 5);
        @(negedge clk);
        chk(int'(cnt_o) == 5, "R1", int'(cnt_o), 5);
        wr(3, 1);
        wr(0, 1);
        repeat (3) @(negedge clk);
        c0 = int'(cnt_o);
        wr_en = 1'b1; wr_sel = 3'd3; wr_data = 8'd50;
        @(negedge clk);
        wr_en = 1'b0;
        ex = (c0 == 6) ? 1 : c0 + 1;
        chk(int'(cnt_o) == ex, "R2", int'(cnt_o), ex);

        // R8: period rewrite while running waits for the period end
        wait_cnt(1);
        wr(2, 4);
        mx = int'(cnt_o);
        for (int g = 0; g < 50 && int'(cnt_o) != 1; g++) begin
            @(negedge clk);
            if (int'(cnt_o) > mx) mx = int'(cnt_o);
        end
        chk(mx == 6, "R8", mx, 6);
        @(negedge clk);
        mx = int'(cnt_o);
        for (int g = 0; g < 50 && int'(cnt_o) != 1; g++) begin
            @(negedge clk);
            if (int'(cnt_o) > mx) mx = int'(cnt_o);
        end
        chk(mx == 4, "R8", mx, 4);

        // R1: stop clears and holds, output inactive
        wr(0, 0);
        chk(int'(cnt_o) == 0, "R1", int'(cnt_o), 0);
        chk(pwm_o == 1'b1, "R1", int'(pwm_o), 1);
        repeat (5) @(negedge clk);
        chk(int'(cnt_o) == 0, "R1", int'(cnt_o), 0);
        wr(0, 2);
        chk(pwm_o == 1'b0, "R1", int'(pwm_o), 0);

        // R5: sticky flag, clear only with bit 0 set
        chk(flag_o == 1'b1, "R5", int'(flag_o), 1);
        wr(4, 0);
        chk(flag_o == 1'b1, "R5", int'(flag_o), 1);
        wr(4, 1);
        chk(flag_o == 1'b0, "R5", int'(flag_o), 0);

        // R6: entry above the period climbs to the maximum and wraps to one
        setup(2, 4, 10);
        wr(0, 1);
        chk(int'(cnt_o) == 10, "R6", int'(cnt_o), 10);
        seen = 1'b0;
        for (int k = 1; k <= CMAX - 10; k++) begin
            @(negedge clk);
            if (flag_o) seen = 1'b1;
        end
        chk(int'(cnt_o) == CMAX, "R6", int'(cnt_o), CMAX);
        @(negedge clk);
        chk(int'(cnt_o) == 1, "R6", int'(cnt_o), 1);
        chk(!seen && !flag_o, "R6", int'(flag_o), 0);
        repeat (4) @(negedge clk);
        chk(int'(cnt_o) == 1 && flag_o, "R6", int'(cnt_o), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule